// File: doc/BRIEF.md
# Instruction Fetch Frontend

This block produces the program-counter stream of a 32-bit in-order processor. It issues word-aligned read commands on a valid/ready command channel, collects the in-order read responses and hands each fetched word, with its address, to the decode stage over a valid/ready output handshake. After reset it fetches sequentially from a reset address parameter. Each accepted command advances the fetch address by four bytes.

Several pipeline stages can request a redirect at once. The block selects the request from the latest stage and restarts fetching at that stage's target. Responses to commands issued on the abandoned path are counted and dropped, so decode never sees them. A parameter sets whether a redirect reaches the command address in the same cycle or one cycle later. A second parameter keeps a command stable until it is accepted. A third turns a bus read error into an access-fault marker on the delivered word.

The number of reads that are in flight or buffered is capped by a parameter. This lets a small response buffer absorb decode backpressure without overflow. Fetching pauses while that budget is spent. Responses must arrive at least one cycle after their command, in command order.

Top module: `fetch_front`

## Requirements
- R1: While reset is held, out_valid is 0. In the first cycle after reset, with no redirect, cmd_valid is 1 and cmd_addr equals RESET_PC.
- R2: Without redirects, out_pc on successive output transfers increases by 4. Each out_word is the response data read from out_pc.
- R3: With REG_REDIRECT=0, and no command held from the previous cycle, a redirect cycle that asserts cmd_valid shows the selected target on cmd_addr in that same cycle.
- R4: With REG_REDIRECT=1, and no command held from the previous cycle, cmd_valid is 0 in the redirect cycle. The next command shows the target one cycle later.
- R5: Bit i of jmp_valid is the request of stage i, and its target is bits [32*i+31:32*i] of jmp_target. When several bits are set, the highest index wins.
- R6: out_valid is 0 in a redirect cycle. The first word delivered after a redirect is the one at the target address. No response to a command issued before the redirect is ever delivered.
- R7: With HOLD_CMD=1, a command that is valid but not accepted stays valid with the same address in the next cycle, even when a redirect arrives.
- R8: With FAULT_EN=1, out_fault is 1 exactly when the response that produced the word had rsp_err set.
- R9: Accepted commands minus received responses never exceed MAX_OUT. While decode stalls and the buffer holds MAX_OUT words, cmd_valid stays 0.
- R10: While out_valid is 1 and out_ready is 0, and no redirect arrives, the next cycle keeps out_valid with the same out_pc and out_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| jmp_valid | input | STAGES | Redirect request per pipeline stage |
| jmp_target | input | 32*STAGES | Redirect target per stage, stage i in slice i |
| cmd_valid | output | 1 | Read command valid |
| cmd_ready | input | 1 | Read command accepted by the bus |
| cmd_addr | output | 32 | Read command word address |
| rsp_valid | input | 1 | Read response valid, in command order |
| rsp_data | input | 32 | Read response word |
| rsp_err | input | 1 | Read response error flag |
| out_valid | output | 1 | Fetched word valid towards decode |
| out_ready | input | 1 | Decode accepts the word |
| out_word | output | 32 | Fetched instruction word |
| out_pc | output | 32 | Address of the fetched word |
| out_fault | output | 1 | Word marked as an instruction access fault |

## Verification
A wrong drop count shows up at out_pc as a word from the abandoned path. This appears on the first transfer after that stale response lands, within a few cycles of the redirect. A wrong fetch address or a missed increment breaks the plus-four sequence on the next delivered word. A leaked in-flight count shows as a stalled fetch: cmd_valid stays 0 and output transfers stop. This is caught once the idle interval passes its limit. A held command that moves is visible on cmd_addr in the very next cycle.

// File: rtl/fetch_front.sv
module fetch_front #(
  parameter logic [31:0] RESET_PC = 32'h0000_0100,
  parameter bit REG_REDIRECT = 1'b0,
  parameter bit HOLD_CMD = 1'b1,
  parameter bit FAULT_EN = 1'b1,
  parameter int MAX_OUT = 4,
  parameter int STAGES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [STAGES-1:0]    jmp_valid,
  input  logic [STAGES*32-1:0] jmp_target,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [31:0]          cmd_addr,
  input  logic                 rsp_valid,
  input  logic [31:0]          rsp_data,
  input  logic                 rsp_err,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [31:0]          out_word,
  output logic [31:0]          out_pc,
  output logic                 out_fault
);
  localparam int CW = $clog2(MAX_OUT + 1);
  localparam int PW = $clog2(MAX_OUT);

  logic          jv;
  logic [31:0]   jt;
  logic [31:0]   pc, hold_addr, rpc;
  logic          held, stale;
  logic [CW-1:0] inflt, drop, cnt;
  logic [PW-1:0] wp, rp;
  logic          room, acc, acc_stale, take, pop, dec_drop;

  logic [31:0] bword [MAX_OUT];
  logic [31:0] bpc   [MAX_OUT];
  logic        berr  [MAX_OUT];

  always_comb begin
    jv = 1'b0;
    jt = 32'h0;
    for (int i = 0; i < STAGES; i++) begin
      if (jmp_valid[i]) begin
        jv = 1'b1;
        jt = jmp_target[i*32 +: 32];
      end
    end
  end

  assign room      = (inflt + (jv ? CW'(0) : cnt)) < CW'(MAX_OUT);
  assign cmd_valid = held | (room & ~(REG_REDIRECT & jv));
  assign cmd_addr  = held ? hold_addr : ((!REG_REDIRECT && jv) ? jt : pc);
  assign acc       = cmd_valid & cmd_ready;
  assign acc_stale = acc & held & (stale | jv);
  assign dec_drop  = rsp_valid & (drop != '0);
  assign take      = rsp_valid & ~jv & (drop == '0);
  assign out_valid = (cnt != '0) & ~jv;
  assign pop       = out_valid & out_ready;
  assign out_word  = bword[rp];
  assign out_pc    = bpc[rp];
  assign out_fault = FAULT_EN & berr[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc        <= RESET_PC;
      hold_addr <= RESET_PC;
      rpc       <= RESET_PC;
      held      <= 1'b0;
      stale     <= 1'b0;
      inflt     <= '0;
      drop      <= '0;
      cnt       <= '0;
      wp        <= '0;
      rp        <= '0;
    end else begin
      if (jv)
        pc <= (!REG_REDIRECT && !held && acc) ? jt + 32'd4 : jt;
      else if (acc && !(held && stale))
        pc <= pc + 32'd4;

      held  <= HOLD_CMD & cmd_valid & ~cmd_ready;
      stale <= held & (stale | jv);
      if (!held) hold_addr <= cmd_addr;

      inflt <= inflt + CW'(acc) - CW'(rsp_valid);
      drop  <= jv ? inflt - CW'(rsp_valid) + CW'(acc_stale)
                  : drop - CW'(dec_drop) + CW'(acc_stale);

      if (jv) begin
        rpc <= jt;
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (take) begin
          rpc <= rpc + 32'd4;
          wp  <= wp + PW'(1);
        end
        if (pop) rp <= rp + PW'(1);
        cnt <= cnt + CW'(take) - CW'(pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      bword[wp] <= rsp_data;
      bpc[wp]   <= rpc;
      berr[wp]  <= rsp_err;
    end
  end
endmodule

// File: rtl/fetch_front_chk.sv
module fetch_front_chk #(
  parameter logic [31:0] RESET_PC = 32'h0000_0100,
  parameter bit REG_REDIRECT = 1'b0,
  parameter bit HOLD_CMD = 1'b1,
  parameter int MAX_OUT = 4,
  parameter int STAGES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STAGES-1:0] jmp_valid,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [31:0]       cmd_addr,
  input logic              rsp_valid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_word,
  input logic [31:0]       out_pc
);
  logic        first, wait_q, ostall_q, have_last;
  logic [31:0] addr_q, opc_q, oword_q, last_pc;
  logic [7:0]  outstanding;
  logic        jany;

  assign jany = |jmp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first       <= 1'b1;
      wait_q      <= 1'b0;
      ostall_q    <= 1'b0;
      have_last   <= 1'b0;
      addr_q      <= '0;
      opc_q       <= '0;
      oword_q     <= '0;
      last_pc     <= '0;
      outstanding <= '0;
    end else begin
      first       <= 1'b0;
      wait_q      <= cmd_valid & ~cmd_ready;
      addr_q      <= cmd_addr;
      ostall_q    <= out_valid & ~out_ready & ~jany;
      opc_q       <= out_pc;
      oword_q     <= out_word;
      outstanding <= outstanding + 8'(cmd_valid & cmd_ready) - 8'(rsp_valid);
      if (jany) have_last <= 1'b0;
      else if (out_valid && out_ready) begin
        have_last <= 1'b1;
        last_pc   <= out_pc;
      end
    end
  end

  assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    first && !jany |-> cmd_valid && cmd_addr == RESET_PC);

  assert_step_four_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && have_last && !jany |-> out_pc == last_pc + 32'd4);

  assert_reg_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    REG_REDIRECT && jany && !wait_q |-> !cmd_valid);

  assert_no_out_on_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    jany |-> !out_valid);

  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    HOLD_CMD && wait_q |-> cmd_valid && cmd_addr == addr_q);

  assert_in_flight_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= 8'(MAX_OUT));

  assert_out_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ostall_q && !jany |-> out_valid && out_pc == opc_q && out_word == oword_q);
endmodule

bind fetch_front fetch_front_chk #(
  .RESET_PC(RESET_PC), .REG_REDIRECT(REG_REDIRECT), .HOLD_CMD(HOLD_CMD),
  .MAX_OUT(MAX_OUT), .STAGES(STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .jmp_valid(jmp_valid), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .rsp_valid(rsp_valid),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_pc(out_pc)
);

// File: tb/fetch_front_tb.sv
module fetch_front_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC = 32'h0000_0100;
  localparam int NCYC = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]   jmp_valid = '0;
  logic [127:0] jmp_target = '0;
  logic        cmd_valid [2];
  logic        cmd_ready [2];
  logic [31:0] cmd_addr  [2];
  logic        rsp_valid [2];
  logic [31:0] rsp_data  [2];
  logic        rsp_err   [2];
  logic        out_valid [2];
  logic        out_ready [2];
  logic [31:0] out_word  [2];
  logic [31:0] out_pc    [2];
  logic        out_fault [2];

  fetch_front #(.RESET_PC(RST_PC), .REG_REDIRECT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .jmp_valid(jmp_valid), .jmp_target(jmp_target),
    .cmd_valid(cmd_valid[0]), .cmd_ready(cmd_ready[0]), .cmd_addr(cmd_addr[0]),
    .rsp_valid(rsp_valid[0]), .rsp_data(rsp_data[0]), .rsp_err(rsp_err[0]),
    .out_valid(out_valid[0]), .out_ready(out_ready[0]), .out_word(out_word[0]),
    .out_pc(out_pc[0]), .out_fault(out_fault[0]));

  fetch_front #(.RESET_PC(RST_PC), .REG_REDIRECT(1'b1)) u_dut_reg (
    .clk(clk), .rst_n(rst_n), .jmp_valid(jmp_valid), .jmp_target(jmp_target),
    .cmd_valid(cmd_valid[1]), .cmd_ready(cmd_ready[1]), .cmd_addr(cmd_addr[1]),
    .rsp_valid(rsp_valid[1]), .rsp_data(rsp_data[1]), .rsp_err(rsp_err[1]),
    .out_valid(out_valid[1]), .out_ready(out_ready[1]), .out_word(out_word[1]),
    .out_pc(out_pc[1]), .out_fault(out_fault[1]));

  int nchk = 0, nerr = 0;

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[31:16]};
  endfunction

  function automatic logic err_of(input logic [31:0] a);
    return a[5:2] == 4'hD;
  endfunction

  function automatic logic [31:0] pick(input logic [3:0] m, input logic [127:0] t);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) if (m[i]) r = t[i*32 +: 32];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  logic [31:0] qa [2][16];
  int qd [2][16];
  int qh [2], qt [2], qc [2], lastdue [2], idle [2];
  logic [31:0] exp_pc [2], paddr [2], ppc [2], pword [2];
  bit pw [2], pstall [2];

  initial begin
    bit first, pj, jn, stop;
    logic [31:0] tgt, ptgt;
    logic [3:0] mask;
    void'($urandom(32'd1234));
    for (int k = 0; k < 2; k++) begin
      cmd_ready[k] = 0; rsp_valid[k] = 0; rsp_data[k] = 0; rsp_err[k] = 0; out_ready[k] = 0;
      qh[k] = 0; qt[k] = 0; qc[k] = 0; lastdue[k] = 0; idle[k] = 0;
      exp_pc[k] = RST_PC; pw[k] = 0; pstall[k] = 0;
      paddr[k] = 0; ppc[k] = 0; pword[k] = 0;
    end
    repeat (3) begin
      @(negedge clk);
      for (int k = 0; k < 2; k++) chk(out_valid[k] == 0, "R1 out_valid in reset", 32'(out_valid[k]), 0);
    end
    rst_n = 1'b1;
    first = 1; pj = 0; ptgt = 0; stop = 0;
    for (int c = 1; c <= NCYC && !stop; c++) begin
      bit stallph, holdph;
      stallph = (c >= 1000 && c < 1040);
      holdph  = (c >= 600 && c < 612);
      if (c == 150) mask = 4'b1111;
      else if (c == 400) mask = 4'b0101;
      else if (c == 605) mask = 4'b0010;
      else if (first || (c >= 990 && c < 1045) || holdph) mask = 4'b0000;
      else mask = ($urandom % 30 == 0) ? 4'(1 + $urandom % 15) : 4'b0000;
      for (int i = 0; i < 4; i++) jmp_target[i*32 +: 32] = 32'h1000 | ($urandom & 32'h0000_0FFC);
      jmp_valid = mask;
      jn = (mask != 0);
      tgt = pick(mask, jmp_target);
      for (int k = 0; k < 2; k++) begin
        out_ready[k] = stallph ? 1'b0 : ($urandom % 4 != 0);
        cmd_ready[k] = stallph ? 1'b1 : holdph ? 1'b0 : ($urandom % 3 != 0);
        if (qc[k] > 0 && qd[k][qh[k]] <= c) begin
          rsp_valid[k] = 1;
          rsp_data[k]  = word_of(qa[k][qh[k]]);
          rsp_err[k]   = err_of(qa[k][qh[k]]);
          qh[k] = (qh[k] + 1) % 16; qc[k]--;
        end else rsp_valid[k] = 0;
      end
      #1;
      for (int k = 0; k < 2; k++) begin
        if (first) begin
          chk(cmd_valid[k] == 1, "R1 first cmd_valid", 32'(cmd_valid[k]), 1);
          chk(cmd_addr[k] == RST_PC, "R1 first cmd_addr", cmd_addr[k], RST_PC);
        end
        if (pw[k]) chk(cmd_valid[k] && cmd_addr[k] == paddr[k], "R7 held command", cmd_addr[k], paddr[k]);
        if (jn) begin
          if (k == 0 && !pw[k] && cmd_valid[k])
            chk(cmd_addr[k] == tgt, (mask[3:1] != 0 && mask[0]) ? "R3 R5 same-cycle target" : "R3 same-cycle target", cmd_addr[k], tgt);
          if (k == 1 && !pw[k]) chk(cmd_valid[k] == 0, "R4 no command in jump cycle", 32'(cmd_valid[k]), 0);
          chk(out_valid[k] == 0, "R6 no output in jump cycle", 32'(out_valid[k]), 0);
          exp_pc[k] = tgt;
        end
        if (k == 1 && pj && !jn && !pw[k] && cmd_valid[k])
          chk(cmd_addr[k] == ptgt, "R4 R5 target one cycle later", cmd_addr[k], ptgt);
        if (pstall[k] && !jn)
          chk(out_valid[k] && out_pc[k] == ppc[k] && out_word[k] == pword[k], "R10 stalled output", out_pc[k], ppc[k]);
        if (cmd_valid[k] && cmd_ready[k]) begin
          int d;
          d = c + 1 + int'($urandom % 3);
          if (d <= lastdue[k]) d = lastdue[k] + 1;
          lastdue[k] = d;
          qa[k][qt[k]] = cmd_addr[k]; qd[k][qt[k]] = d;
          qt[k] = (qt[k] + 1) % 16; qc[k]++;
          chk(qc[k] <= 4, "R9 in-flight cap", 32'(qc[k]), 4);
        end
        if (out_valid[k] && out_ready[k]) begin
          chk(out_pc[k] == exp_pc[k], "R2 R6 address order", out_pc[k], exp_pc[k]);
          chk(out_word[k] == word_of(exp_pc[k]), "R2 word content", out_word[k], word_of(exp_pc[k]));
          chk(out_fault[k] == err_of(exp_pc[k]), "R8 fault flag", 32'(out_fault[k]), 32'(err_of(exp_pc[k])));
          exp_pc[k] += 4;
          idle[k] = 0;
        end else if (++idle[k] > 300) begin
          chk(0, "R9 watchdog no progress", 32'(idle[k]), 300);
          stop = 1;
        end
        if (c == 1039) chk(cmd_valid[k] == 0, "R9 no fetch while buffer full", 32'(cmd_valid[k]), 0);
        pw[k] = cmd_valid[k] && !cmd_ready[k];
        paddr[k] = cmd_addr[k];
        pstall[k] = out_valid[k] && !out_ready[k];
        ppc[k] = out_pc[k];
        pword[k] = out_word[k];
      end
      first = 0; pj = jn; ptgt = tgt;
      @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule